// File: doc/BRIEF.md
# Packed-Column Shift-Weight Systolic Array

This block is a weight-stationary systolic array for matrix products whose weight matrix has been compressed. Sparse weight columns are merged ahead of time so that each physical column carries only nonzero weights. The merged columns can come from up to eight logical columns, with at most one weight kept per row. Each cell holds one such weight as a small code: an enable bit, a sign bit, a shift amount (the weight is a signed power of two), and a lane index. The lane index picks which of the eight data values arriving on that row the cell multiplies. Partial sums move down the columns. Data groups move right across the rows.

Software first loads the codes one word per cycle, column by column, while the load enable is high. It then streams input vectors, one per cycle if it wishes. Each vector carries one group of eight data lanes per array row. Inside the block the rows are skewed and the column results are de-skewed. All column sums for a vector therefore appear together, with one valid strobe, a fixed number of cycles after the vector was accepted.

Top module: `packed_sa`

## Requirements
- R1: After reset, out_valid_o is low and every column sum on out_sum_o is zero.
- R2: Each column sum is the total over all rows of that row's cell term. A cell term takes the data lane chosen by code bits [2:0] from its row's group and shifts it left by code bits [6:3]. It is negated when code bit [7] is set. Data for row r, lane l sits at in_data_i bits (r*8+l)*DATA_W upward (signed). Column c's sum sits at out_sum_o bits c*ACC_W upward (signed).
- R3: A cell whose enable bit [8] is clear adds nothing to its column.
- R4: While load_enable_i is high, one code word is taken per cycle. Word number i goes to column i/ROWS, row i%ROWS. Dropping load_enable_i restarts the count at word 0.
- R5: Within one load window, words beyond ROWS*COLS are ignored.
- R6: An input vector presented while load_enable_i is high is not accepted and never produces out_valid_o.
- R7: For an input accepted at a clock edge, out_valid_o and all column sums become visible after exactly ROWS+COLS-1 clock edges, counting that edge. No column is earlier or later than the others.
- R8: Vectors may be presented on consecutive cycles. Their results emerge on consecutive cycles, in order, without interfering with one another.
- R9: Sums are exact for the extreme operands: all lanes at the most negative or most positive data value, maximum shift, in every row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_enable_i | input | 1 | Code load window |
| load_word_i | input | 9 | Cell code: [8] enable, [7] negate, [6:3] shift, [2:0] lane |
| in_valid_i | input | 1 | Input vector strobe |
| in_data_i | input | ROWS*8*DATA_W | Eight signed lanes per row |
| out_valid_o | output | 1 | Column sums valid |
| out_sum_o | output | COLS*ACC_W | Signed sum per column |

## Verification
The input strobe and the load enable can both be high in the same cycle. The bench provokes this by keeping in_valid_i high for a whole load window with live data on the lanes. It then requires out_valid_o to stay low during the window and for ROWS+COLS+1 cycles after it. It also requires the freshly loaded codes to produce correct sums afterwards. A second overlap is a load window that runs past ROWS*COLS words while the counter is saturated. The bench feeds extra words that would change every sum and confirms that the results still match the first ROWS*COLS codes.

// File: rtl/packed_sa_pkg.sv
package packed_sa_pkg;
  localparam int LANES      = 8;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int SHIFT_W    = 4;

  typedef struct packed {
    logic                  en;
    logic                  neg;
    logic [SHIFT_W-1:0]    sh;
    logic [LANE_IDX_W-1:0] lane;
  } cell_wt_t;

  localparam int WT_W = $bits(cell_wt_t);
endpackage

// File: rtl/packed_sa_delay.sv
module packed_sa_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] st_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
      end else begin
        st_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) st_q[i] <= st_q[i-1];
      end
    end
    assign q_o = st_q[DEPTH-1];
  end
endmodule

// File: rtl/packed_sa_loader.sv
module packed_sa_loader #(
  parameter int TOTAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_enable_i,
  output logic [TOTAL-1:0] we_o
);
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!load_enable_i)             cnt_q <= '0;
    else if (cnt_q != CNT_W'(TOTAL))     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_we
    assign we_o[i] = load_enable_i && (cnt_q == CNT_W'(i));
  end

  // R5: saturated counter stays saturated for the rest of the window
  a_r5_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_enable_i && cnt_q == CNT_W'(TOTAL)) |=> (cnt_q == CNT_W'(TOTAL)));
endmodule

// File: rtl/packed_sa_cell.sv
module packed_sa_cell
  import packed_sa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wt_we_i,
  input  cell_wt_t                wt_i,
  input  logic [LANES*DATA_W-1:0] lanes_i,
  input  logic [ACC_W-1:0]        psum_i,
  output logic [ACC_W-1:0]        psum_o
);
  cell_wt_t                 wt_q;
  logic signed [DATA_W-1:0] sel;
  logic signed [ACC_W-1:0]  ext, mag, term;
  logic [ACC_W-1:0]         psum_d, psum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wt_q <= '0;
    else if (wt_we_i) wt_q <= wt_i;
  end

  always_comb begin
    sel    = lanes_i[wt_q.lane*DATA_W +: DATA_W];
    ext    = {{(ACC_W-DATA_W){sel[DATA_W-1]}}, sel};
    mag    = ext <<< wt_q.sh;
    term   = wt_q.neg ? -mag : mag;
    psum_d = wt_q.en ? psum_i + term : psum_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psum_q <= '0;
    else         psum_q <= psum_d;
  end

  assign psum_o = psum_q;

  // R3: empty cell forwards the incoming partial sum untouched
  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wt_q.en) |=> (psum_o == $past(psum_i)));
endmodule

// File: rtl/packed_sa.sv
module packed_sa
  import packed_sa_pkg::*;
#(
  parameter  int ROWS   = 4,
  parameter  int COLS   = 4,
  parameter  int DATA_W = 8,
  localparam int ACC_W  = DATA_W + (2**SHIFT_W - 1) + $clog2(ROWS) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_enable_i,
  input  logic [WT_W-1:0]              load_word_i,
  input  logic                         in_valid_i,
  input  logic [ROWS*LANES*DATA_W-1:0] in_data_i,
  output logic                         out_valid_o,
  output logic [COLS*ACC_W-1:0]        out_sum_o
);
  localparam int GRP_W   = LANES * DATA_W;
  localparam int TOTAL   = ROWS * COLS;
  localparam int LATENCY = ROWS + COLS - 1;

  logic [TOTAL-1:0] cell_we;
  cell_wt_t         load_wt;
  logic             accept;
  logic [GRP_W-1:0] h_bus [ROWS][COLS];
  logic [ACC_W-1:0] v_bus [ROWS+1][COLS];

  assign load_wt = cell_wt_t'(load_word_i);
  assign accept  = in_valid_i && !load_enable_i;

  packed_sa_loader #(.TOTAL(TOTAL)) u_loader (
    .clk_i, .rst_ni, .load_enable_i, .we_o(cell_we)
  );

  packed_sa_delay #(.W(1), .DEPTH(LATENCY)) u_vld (
    .clk_i, .rst_ni, .d_i(accept), .q_o(out_valid_o)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    packed_sa_delay #(.W(GRP_W), .DEPTH(r)) u_skew (
      .clk_i, .rst_ni, .d_i(in_data_i[r*GRP_W +: GRP_W]), .q_o(h_bus[r][0])
    );
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (c < COLS - 1) begin : g_hop
        packed_sa_delay #(.W(GRP_W), .DEPTH(1)) u_hop (
          .clk_i, .rst_ni, .d_i(h_bus[r][c]), .q_o(h_bus[r][c+1])
        );
      end
      packed_sa_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cell (
        .clk_i, .rst_ni,
        .wt_we_i (cell_we[c*ROWS + r]),
        .wt_i    (load_wt),
        .lanes_i (h_bus[r][c]),
        .psum_i  (v_bus[r][c]),
        .psum_o  (v_bus[r+1][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_out
    assign v_bus[0][c] = '0;
    packed_sa_delay #(.W(ACC_W), .DEPTH(COLS-1-c)) u_deskew (
      .clk_i, .rst_ni, .d_i(v_bus[ROWS][c]), .q_o(out_sum_o[c*ACC_W +: ACC_W])
    );
  end

  // R4: the loader never writes two cells in one cycle
  a_r4_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cell_we));

  // R7: a valid strobe always comes with fully defined sums
  a_r7_known_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown(out_sum_o));
endmodule

// File: tb/packed_sa_bench.sv
module packed_sa_bench;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int DATA_W = 8;
  localparam int LANES  = 8;
  localparam int ACC_W  = DATA_W + 15 + $clog2(ROWS) + 1;
  localparam int BUS_W  = ROWS * LANES * DATA_W;
  localparam int TOTAL  = ROWS * COLS;
  localparam int LAT    = ROWS + COLS - 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               load_en;
  logic [8:0]         load_word;
  logic               in_valid;
  logic [BUS_W-1:0]   in_data;
  logic               out_valid;
  logic [COLS*ACC_W-1:0] out_sum;

  int checks = 0;
  int fails  = 0;

  logic [8:0]       wts  [ROWS][COLS];
  logic [BUS_W-1:0] vecs [16];

  always #10 clk = ~clk;

  packed_sa #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_packed_sa (
    .clk_i(clk), .rst_ni(rst_n), .load_enable_i(load_en), .load_word_i(load_word),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_sum_o(out_sum)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint col_exp(input logic [BUS_W-1:0] v, input int c);
    longint s = 0;
    for (int r = 0; r < ROWS; r++) begin
      logic [8:0] w;
      longint x, t;
      w = wts[r][c];
      if (w[8]) begin
        x = longint'($signed(v[(r*LANES + int'(w[2:0]))*DATA_W +: DATA_W]));
        t = x * (longint'(1) << w[6:3]);
        if (w[7]) t = -t;
        s += t;
      end
    end
    return s;
  endfunction

  function automatic longint col_act(input int c);
    return longint'($signed(out_sum[c*ACC_W +: ACC_W]));
  endfunction

  task automatic rand_vecs(input int n);
    for (int j = 0; j < n; j++)
      for (int k = 0; k < BUS_W/32; k++) vecs[j][k*32 +: 32] = $urandom;
  endtask

  task automatic rand_wts(input bit all_en);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        wts[r][c] = 9'($urandom);
        if (all_en) wts[r][c][8] = 1'b1;
      end
  endtask

  task automatic load_all(input int extra, input bit hold_valid);
    load_en  = 1'b1;
    in_valid = hold_valid;
    in_data  = {BUS_W/32{32'h7f7f_7f7f}};
    for (int i = 0; i < TOTAL + extra; i++) begin
      load_word = (i < TOTAL) ? wts[i % ROWS][i / ROWS] : 9'h1ff;
      @(negedge clk);
      if (hold_valid) chk(out_valid == 1'b0, "R6", "valid during load", out_valid, 0);
    end
    load_en   = 1'b0;
    in_valid  = 1'b0;
    load_word = '0;
  endtask

  // Drive vecs[0..n-1] back to back, check each result LAT cycles later
  task automatic stream(input int n, input string req);
    for (int k = 0; k < n + LAT; k++) begin
      if (k >= LAT) begin
        chk(out_valid == 1'b1, "R7", "valid at latency", out_valid, 1);
        for (int c = 0; c < COLS; c++)
          chk(col_act(c) == col_exp(vecs[k-LAT], c), req, $sformatf("col %0d", c),
              col_act(c), col_exp(vecs[k-LAT], c));
      end else begin
        chk(out_valid == 1'b0, "R7", "valid before latency", out_valid, 0);
      end
      in_valid = (k < n);
      if (k < n) in_data = vecs[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8", "valid after stream", out_valid, 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    for (int c = 0; c < COLS; c++)
      chk(col_act(c) == 0, "R1", $sformatf("sum col %0d", c), col_act(c), 0);
  endtask

  task automatic t_single;
    rand_wts(1'b0);
    load_all(0, 1'b0);
    rand_vecs(1);
    stream(1, "R2");
  endtask

  task automatic t_back_to_back;
    rand_wts(1'b1);
    load_all(0, 1'b0);
    rand_vecs(8);
    stream(8, "R8");
  endtask

  task automatic t_bypass;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wts[r][c] = 9'h0ff & 9'($urandom);
    wts[1][2] = 9'h123;
    load_all(0, 1'b0);
    rand_vecs(3);
    stream(3, "R3");
  endtask

  task automatic t_extremes;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wts[r][c] = {1'b1, c[0], 4'hf, 3'(r + c)};
    load_all(0, 1'b0);
    vecs[0] = {BUS_W/8{8'h80}};
    vecs[1] = {BUS_W/8{8'h7f}};
    vecs[2] = {BUS_W/16{16'h7f80}};
    stream(3, "R9");
  endtask

  task automatic t_extra_words;
    rand_wts(1'b1);
    load_all(5, 1'b0);
    rand_vecs(2);
    stream(2, "R5");
  endtask

  task automatic t_restart;
    load_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      load_word = 9'h1ff;
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    rand_wts(1'b1);
    load_all(0, 1'b0);
    rand_vecs(2);
    stream(2, "R4");
  endtask

  task automatic t_load_block;
    rand_wts(1'b1);
    load_all(0, 1'b1);
    for (int k = 0; k < LAT + 2; k++) begin
      chk(out_valid == 1'b0, "R6", "valid after load window", out_valid, 0);
      @(negedge clk);
    end
    rand_vecs(2);
    stream(2, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_word = '0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_back_to_back();
    t_bypass();
    t_extremes();
    t_extra_words();
    t_restart();
    t_load_block();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule